// File: doc/BRIEF.md
# Lockable Watchdog Timer

A 32-bit down-counting watchdog behind a small synchronous register bus. The counter reloads from a programmable interval whenever it runs out, and each time-out sets a raw status flag that can raise either a standard or a non-maskable interrupt. When software fails to clear the flag before the following time-out, the block pulses a reset output, or, in test mode, withholds the reset and records its cause instead.

Every register write except the test-enable bit is guarded by a key lock that comes out of reset closed. Software first writes the key, then programs the interval and the control bits, and services the timer by writing the clear register. A debug-halt input, qualified by a stall bit, freezes the count while a debugger holds the processor.

Top module: `wdog_timer`

## Requirements
- R1: After reset the interval register and the counter both hold 0xFFFFFFFF, the lock register reads 1, control, test, raw and masked status read 0, and irq, nmi and wdt_rst are low.
- R2: The counter decrements by one on every clock edge when not stalled; a write to the interval register (0x000) loads the written value into the counter at the same edge.
- R3: When the counter is 0 at an edge, that edge sets raw status (0x010 bit 0) and reloads the counter from the interval, so a time-out lands V+1 edges after an interval V is written.
- R4: Writing 0 to the interval register sets raw status at the write edge.
- R5: A write of any value to the clear register (0x00C) clears raw status and the cause flag and reloads the counter from the interval at the write edge.
- R6: The control register (0x008) holds interrupt enable in bit 0, reset enable in bit 1 and non-maskable select in bit 2; once bit 0 is set, writes cannot clear it.
- R7: Masked status (0x014 bit 0) equals raw status AND interrupt enable; with interrupt enable set and a pending event, irq is high when bit 2 is 0 and nmi is high when bit 2 is 1.
- R8: A time-out that occurs while raw status is already set and reset enable is 1 drives wdt_rst high for the one cycle after that edge.
- R9: Writing 0x1ACCE551 to the lock register (0xC00) unlocks and it then reads 0; any other value locks and it reads 1; while locked, writes to interval, control, clear and the stall bit have no effect.
- R10: Test register (0x418) bit 0 is writable even while locked; when it is 1, a reset event leaves wdt_rst low, sets cause register (0x41C) bit 1 and raises the interrupt; cause bit 0 mirrors raw status.
- R11: With test register bit 8 set and dbg_halt high, the counter holds its value; it resumes when dbg_halt falls, and without bit 8 dbg_halt has no effect.
- R12: The counter reads at 0x004; unmapped addresses and reserved bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_halt | input | 1 | Debugger halt request |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Standard interrupt |
| nmi | output | 1 | Non-maskable interrupt |
| wdt_rst | output | 1 | One-cycle reset request |

## Verification
Every register write takes effect at the edge that samples it, and read data follows the address combinationally, so a readback is due in the low phase just after the write edge. The counter shows V at that point, V-k after k further edges, and raw status rises V+1 edges after the write; the reset pulse follows the second such time-out and is visible only in the cycle after it. The bench drives on falling edges, samples before the next rising edge, and counts edges from the write to place every check on its due cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned WD_OFS_LOAD  = 'h000;
  localparam int unsigned WD_OFS_VALUE = 'h004;
  localparam int unsigned WD_OFS_CTRL  = 'h008;
  localparam int unsigned WD_OFS_CLR   = 'h00C;
  localparam int unsigned WD_OFS_RAW   = 'h010;
  localparam int unsigned WD_OFS_MSK   = 'h014;
  localparam int unsigned WD_OFS_TEST  = 'h418;
  localparam int unsigned WD_OFS_CAUSE = 'h41C;
  localparam int unsigned WD_OFS_LOCK  = 'hC00;

  localparam logic [31:0] WD_KEY = 32'h1ACC_E551;

  localparam int unsigned CTRL_INTEN_BIT = 0;
  localparam int unsigned CTRL_RESEN_BIT = 1;
  localparam int unsigned CTRL_NMI_BIT   = 2;
  localparam int unsigned TEST_EN_BIT    = 0;
  localparam int unsigned TEST_STALL_BIT = 8;
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              raw_i,
  input  logic              cause_i,
  output logic [DATA_W-1:0] load_o,
  output logic              reload_o,
  output logic [DATA_W-1:0] reload_val_o,
  output logic              zero_wr_o,
  output logic              clr_o,
  output logic              inten_o,
  output logic              resen_o,
  output logic              nmi_sel_o,
  output logic              stall_o,
  output logic              test_o
);
  logic [DATA_W-1:0] load_q, load_d;
  logic              locked_q, locked_d;
  logic              inten_q, inten_d;
  logic              resen_q, resen_d;
  logic              nmi_q, nmi_d;
  logic              stall_q, stall_d;
  logic              test_q, test_d;

  logic hit_load, hit_ctrl, hit_clr, hit_test, hit_lock;
  logic ok_load, ok_ctrl, ok_clr, ok_test;

  assign hit_load = bus_we && (bus_addr == ADDR_W'(WD_OFS_LOAD));
  assign hit_ctrl = bus_we && (bus_addr == ADDR_W'(WD_OFS_CTRL));
  assign hit_clr  = bus_we && (bus_addr == ADDR_W'(WD_OFS_CLR));
  assign hit_test = bus_we && (bus_addr == ADDR_W'(WD_OFS_TEST));
  assign hit_lock = bus_we && (bus_addr == ADDR_W'(WD_OFS_LOCK));

  assign ok_load = hit_load && !locked_q;
  assign ok_ctrl = hit_ctrl && !locked_q;
  assign ok_clr  = hit_clr  && !locked_q;
  assign ok_test = hit_test && !locked_q;

  // next-state logic
  always_comb begin
    locked_d = locked_q;
    load_d   = load_q;
    inten_d  = inten_q;
    resen_d  = resen_q;
    nmi_d    = nmi_q;
    stall_d  = stall_q;
    test_d   = test_q;
    if (hit_lock) locked_d = (bus_wdata != DATA_W'(WD_KEY));
    if (ok_load)  load_d   = bus_wdata;
    if (ok_ctrl) begin
      inten_d = inten_q | bus_wdata[CTRL_INTEN_BIT];
      resen_d = bus_wdata[CTRL_RESEN_BIT];
      nmi_d   = bus_wdata[CTRL_NMI_BIT];
    end
    if (ok_test)  stall_d  = bus_wdata[TEST_STALL_BIT];
    if (hit_test) test_d   = bus_wdata[TEST_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
      load_q   <= '1;
      inten_q  <= 1'b0;
      resen_q  <= 1'b0;
      nmi_q    <= 1'b0;
      stall_q  <= 1'b0;
      test_q   <= 1'b0;
    end else begin
      locked_q <= locked_d;
      load_q   <= load_d;
      inten_q  <= inten_d;
      resen_q  <= resen_d;
      nmi_q    <= nmi_d;
      stall_q  <= stall_d;
      test_q   <= test_d;
    end
  end

  assign load_o       = load_q;
  assign reload_o     = ok_load || ok_clr;
  assign reload_val_o = ok_load ? bus_wdata : load_q;
  assign zero_wr_o    = ok_load && (bus_wdata == '0);
  assign clr_o        = ok_clr;
  assign inten_o      = inten_q;
  assign resen_o      = resen_q;
  assign nmi_sel_o    = nmi_q;
  assign stall_o      = stall_q;
  assign test_o       = test_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(WD_OFS_LOAD):  bus_rdata = load_q;
      ADDR_W'(WD_OFS_VALUE): bus_rdata = cnt_i;
      ADDR_W'(WD_OFS_CTRL): begin
        bus_rdata[CTRL_INTEN_BIT] = inten_q;
        bus_rdata[CTRL_RESEN_BIT] = resen_q;
        bus_rdata[CTRL_NMI_BIT]   = nmi_q;
      end
      ADDR_W'(WD_OFS_RAW):   bus_rdata[0] = raw_i;
      ADDR_W'(WD_OFS_MSK):   bus_rdata[0] = raw_i & inten_q;
      ADDR_W'(WD_OFS_TEST): begin
        bus_rdata[TEST_EN_BIT]    = test_q;
        bus_rdata[TEST_STALL_BIT] = stall_q;
      end
      ADDR_W'(WD_OFS_CAUSE): bus_rdata[1:0] = {cause_i, raw_i};
      ADDR_W'(WD_OFS_LOCK):  bus_rdata[0] = locked_q;
      default:               bus_rdata = '0;
    endcase
  end

  // R6
  inten_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inten_q |=> inten_q);

  // R9
  lock_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && hit_load) |=> $stable(load_q));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             timeout_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero   = (cnt_q == '0);
  assign timeout_o = tick && !reload && at_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (reload)       cnt_d = reload_val;
    else if (tick)    cnt_d = at_zero ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reload && cnt_q == '0) |=> (cnt_q == $past(load_val)));

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reload) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_event.sv
module wdog_event (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_timeout,
  input  logic zero_wr,
  input  logic clr,
  input  logic resen,
  input  logic test_en,
  output logic raw_o,
  output logic cause_o,
  output logic rst_o
);
  logic raw_q, raw_d;
  logic cause_q, cause_d;
  logic rst_q, rst_d;
  logic expire, fire;

  assign expire = cnt_timeout || zero_wr;
  assign fire   = expire && raw_q && resen;

  always_comb begin
    raw_d   = raw_q;
    cause_d = cause_q;
    if (clr) begin
      raw_d   = 1'b0;
      cause_d = 1'b0;
    end else begin
      if (expire)           raw_d   = 1'b1;
      if (fire && test_en)  cause_d = 1'b1;
    end
    rst_d = fire && !test_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= 1'b0;
      cause_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      raw_q   <= raw_d;
      cause_q <= cause_d;
      rst_q   <= rst_d;
    end
  end

  assign raw_o   = raw_q;
  assign cause_o = cause_q;
  assign rst_o   = rst_q;

  // R8
  rst_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> raw_q);

  // R10
  rst_blocked_in_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> !$past(test_en));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_halt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              nmi,
  output logic              wdt_rst
);
  logic [DATA_W-1:0] cnt, load_val, reload_val;
  logic reload, zero_wr, clr, inten, resen, nmi_sel, stall, test_en;
  logic raw, cause, cnt_timeout, tick, pending;

  assign tick    = !(stall && dbg_halt);
  assign pending = raw || cause;
  assign irq     = inten && !nmi_sel && pending;
  assign nmi     = inten && nmi_sel && pending;

  wdog_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .cnt_i        (cnt),
    .raw_i        (raw),
    .cause_i      (cause),
    .load_o       (load_val),
    .reload_o     (reload),
    .reload_val_o (reload_val),
    .zero_wr_o    (zero_wr),
    .clr_o        (clr),
    .inten_o      (inten),
    .resen_o      (resen),
    .nmi_sel_o    (nmi_sel),
    .stall_o      (stall),
    .test_o       (test_en)
  );

  wdog_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .reload     (reload),
    .reload_val (reload_val),
    .load_val   (load_val),
    .cnt_o      (cnt),
    .timeout_o  (cnt_timeout)
  );

  wdog_event u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_timeout (cnt_timeout),
    .zero_wr     (zero_wr),
    .clr         (clr),
    .resen       (resen),
    .test_en     (test_en),
    .raw_o       (raw),
    .cause_o     (cause),
    .rst_o       (wdt_rst)
  );

  // R7
  irq_nmi_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && nmi));
endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam logic [11:0] A_LOAD  = 12'h000;
  localparam logic [11:0] A_VALUE = 12'h004;
  localparam logic [11:0] A_CTRL  = 12'h008;
  localparam logic [11:0] A_CLR   = 12'h00C;
  localparam logic [11:0] A_RAW   = 12'h010;
  localparam logic [11:0] A_MSK   = 12'h014;
  localparam logic [11:0] A_TEST  = 12'h418;
  localparam logic [11:0] A_CAUSE = 12'h41C;
  localparam logic [11:0] A_LOCK  = 12'hC00;
  localparam logic [31:0] KEY     = 32'h1ACC_E551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_halt = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, nmi, wdt_rst;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_timer u_wdog_timer (
    .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .nmi(nmi), .wdt_rst(wdt_rst)
  );

  // {write addr, write data, read addr, expected, requirement}
  localparam int NV = 14;
  localparam logic [95:0] VEC [NV] = '{
    {A_LOCK, KEY,          A_LOCK, 32'h0,      8'd9 },  // R9 unlock
    {A_CTRL, 32'h6,        A_CTRL, 32'h6,      8'd6 },  // R6
    {A_CTRL, 32'h0,        A_CTRL, 32'h0,      8'd6 },  // R6
    {A_CTRL, 32'hFFFFFFFE, A_CTRL, 32'h6,      8'd12},  // R12 reserved bits
    {A_CTRL, 32'h0,        A_CTRL, 32'h0,      8'd6 },
    {A_TEST, 32'hFFFFFFFF, A_TEST, 32'h101,    8'd12},  // R12
    {A_TEST, 32'h0,        A_TEST, 32'h0,      8'd10},
    {A_LOAD, 32'h1000,     A_LOAD, 32'h1000,   8'd2 },  // R2
    {12'h02C,32'hFFFFFFFF, 12'h02C,32'h0,      8'd12},  // R12 unmapped
    {A_LOCK, 32'h1234,     A_LOCK, 32'h1,      8'd9 },  // R9 relock
    {A_LOAD, 32'h55,       A_LOAD, 32'h1000,   8'd9 },  // R9 ignored
    {A_TEST, 32'h101,      A_TEST, 32'h1,      8'd10},  // R10 exempt bit
    {A_TEST, 32'h0,        A_TEST, 32'h0,      8'd10},
    {A_LOCK, KEY,          A_LOCK, 32'h0,      8'd9 }
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic rdchk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v0;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rdchk(A_VALUE, 32'hFFFFFFFF, "R1 value");
    rdchk(A_LOAD,  32'hFFFFFFFF, "R1 load");
    rdchk(A_LOCK,  32'h1, "R1 lock");
    rdchk(A_CTRL,  32'h0, "R1 ctrl");
    rdchk(A_RAW,   32'h0, "R1 raw");
    chk("R1 outputs", {29'b0, irq, nmi, wdt_rst}, 32'h0);
    idle(1);
    rdchk(A_VALUE, 32'hFFFFFFFE, "R2 first decrement");

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][95:84], VEC[i][83:52]);
      rdchk(VEC[i][51:40], VEC[i][39:8], $sformatf("R%0d vector %0d", VEC[i][7:0], i));
    end

    // R2 / R3 count and time-out timing
    wr(A_LOAD, 32'd10);
    rdchk(A_VALUE, 32'd10, "R2 load value");
    idle(3);  rdchk(A_VALUE, 32'd7, "R2 decrement");
    idle(7);  rdchk(A_VALUE, 32'd0, "R3 at zero");
    rdchk(A_RAW, 32'h0, "R3 raw before");
    idle(1);  rdchk(A_RAW, 32'h1, "R3 raw set");
    rdchk(A_VALUE, 32'd10, "R3 reload");
    rdchk(A_CAUSE, 32'h1, "R10 cause mirrors raw");
    // R7 masking
    rdchk(A_MSK, 32'h0, "R7 masked off");
    chk("R7 irq masked", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h1);
    rdchk(A_MSK, 32'h1, "R7 masked on");
    chk("R7 irq", {30'b0, irq, nmi}, 32'h2);
    wr(A_CTRL, 32'h0);
    rdchk(A_CTRL, 32'h1, "R6 sticky enable");
    wr(A_CTRL, 32'h5);
    chk("R7 nmi", {30'b0, irq, nmi}, 32'h1);
    wr(A_CTRL, 32'h1);
    // R5 clear
    wr(A_CLR, 32'h0);
    rdchk(A_RAW, 32'h0, "R5 raw cleared");
    rdchk(A_VALUE, 32'd10, "R5 reload");
    // R4 zero load
    wr(A_LOAD, 32'h0);
    rdchk(A_RAW, 32'h1, "R4 zero load");
    wr(A_LOAD, 32'd20);
    wr(A_CLR, 32'h0);

    // R8 reset pulse after the second time-out
    wr(A_CTRL, 32'h3);
    wr(A_LOAD, 32'd4);
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      chk($sformatf("R8 pulse cycle %0d", n), {31'b0, wdt_rst}, {31'b0, n == 10});
    end
    wr(A_CTRL, 32'h1);
    wr(A_CLR, 32'h0);

    // R8 servicing in time avoids reset
    wr(A_CTRL, 32'h3);
    wr(A_LOAD, 32'd4);
    idle(6);
    wr(A_CLR, 32'h0);
    for (int n = 1; n <= 7; n++) begin
      @(negedge clk);
      chk("R8 no pulse after clear", {31'b0, wdt_rst}, 32'h0);
    end
    rdchk(A_RAW, 32'h1, "R3 raw after clear");
    wr(A_CTRL, 32'h1);
    wr(A_CLR, 32'h0);

    // R10 test mode
    wr(A_TEST, 32'h1);
    wr(A_CTRL, 32'h3);
    wr(A_LOAD, 32'd4);
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      chk("R10 reset suppressed", {31'b0, wdt_rst}, 32'h0);
    end
    rdchk(A_CAUSE, 32'h3, "R10 cause set");
    chk("R10 irq", {31'b0, irq}, 32'h1);
    wr(A_CLR, 32'h0);
    rdchk(A_CAUSE, 32'h0, "R5 cause cleared");
    wr(A_CTRL, 32'h1);
    wr(A_TEST, 32'h0);

    // R11 stall
    wr(A_LOAD, 32'd100);
    wr(A_TEST, 32'h100);
    dbg_halt = 1'b1;
    rd(A_VALUE, v0);
    idle(5);
    rdchk(A_VALUE, v0, "R11 held");
    dbg_halt = 1'b0;
    idle(3);
    rdchk(A_VALUE, v0 - 32'd3, "R11 resumed");
    wr(A_TEST, 32'h0);
    dbg_halt = 1'b1;
    rd(A_VALUE, v0);
    idle(4);
    rdchk(A_VALUE, v0 - 32'd4, "R11 halt without stall bit");
    dbg_halt = 1'b0;

    // R9 locked writes
    wr(A_LOAD, 32'h0);
    wr(A_LOAD, 32'd100);
    wr(A_LOCK, 32'h0);
    rdchk(A_LOCK, 32'h1, "R9 locked");
    wr(A_LOAD, 32'd7);
    rdchk(A_LOAD, 32'd100, "R9 load ignored");
    wr(A_CLR, 32'h0);
    rdchk(A_RAW, 32'h1, "R9 clear ignored");
    wr(A_TEST, 32'h101);
    rdchk(A_TEST, 32'h1, "R10 test bit while locked");
    wr(A_TEST, 32'h0);
    wr(A_LOCK, KEY);
    rdchk(A_LOCK, 32'h0, "R9 unlocked");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule